// File: doc/BRIEF.md
# Multi-Device ROM Read Sequencer

This block sits on the host side of a bank of byte-wide read-only memory devices that share one data bus. The host presents a read request carrying a wide address. The upper bits choose the device and the lower bits are placed on the shared address lines. The block selects the device through its own active-low chip enable. It then opens the single shared active-low output enable, which acts as the read strobe. After the device's access delays have passed, it captures the byte and returns it with a one-cycle valid pulse.

All device delays are given in nanoseconds and are converted into clock cycles by rounding up against the clock period. The output enable is held back until the address-to-data delay minus the output-enable-to-data delay has passed, so the read strobe is open no longer than needed. When the next read targets a different device, the block waits until the previous device has let go of the bus before that device is enabled, so two devices never drive the bus together. Reads to the same device skip this wait. While idle, every device is deselected and sits in its low-power state.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low, every bit of rom_ce_n is high and rom_oe_n is high.
- R2: The device index is req_addr[AW-1:DEV_AW] and rom_addr carries req_addr[DEV_AW-1:0]. During an access only rom_ce_n[index] is low, and at no time is more than one bit of rom_ce_n low.
- R3: rom_oe_n goes low only while exactly one chip enable is low. It falls LEAD clock edges after the chip-enable edge, where LEAD = ceil((max(T_ADDR_NS,T_CE_NS) - T_OE_NS)/CLK_PERIOD_NS), which is 3 with the defaults.
- R4: The data byte is captured on the clock edge DONE+1 after the chip-enable edge, where DONE = max(ceil(max(T_ADDR_NS,T_CE_NS)/P), LEAD + ceil(T_OE_NS/P)). With the defaults, when no release wait applies, rsp_valid is seen 9 cycles after the accepting edge, with the byte the device drives at that address.
- R5: rsp_valid is a single-cycle pulse, and rsp_data holds the captured byte while it is high.
- R6: Chip enable and output enable both rise on the capture edge. A chip enable for a different device than the last one falls no earlier than REL = ceil(T_REL_NS/P) edges after that capture edge (5 by default). A request accepted k edges after the capture edge therefore completes in DONE+1+max(0,REL-k) cycles.
- R7: A read to the same device as the previous read is not delayed by the release wait.
- R8: req_ready is high only in the idle state. req_valid and req_addr presented while a read is in progress have no effect on that read or on its result.
- R9: Whenever req_ready is high, all chip enables and the output enable are high, so deselected devices remain in standby.
- R10: rom_addr and rom_ce_n stay unchanged for as long as rom_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW (20) | Device index in upper bits, device byte address in lower bits |
| rsp_valid | output | 1 | One-cycle pulse marking a returned byte |
| rsp_data | output | DW (8) | Returned byte |
| rom_addr | output | DEV_AW (18) | Shared address lines to all devices |
| rom_ce_n | output | NUM_DEV (4) | Active-low chip enable, one per device |
| rom_oe_n | output | 1 | Shared active-low output enable |
| rom_dq_in | input | DW (8) | Shared data bus from the devices |

## Verification
The device model in the bench drives valid data only once the chip-enable, output-enable and address delays have all passed in real time. It drives a corrupted byte before that, so a controller that captures even one edge early returns the wrong value. The model also keeps each device driving for the release time after it is deselected. Back-to-back reads that alternate devices at gaps of zero to seven cycles therefore reveal a missing or short turnaround as two drivers at once, and reveal an over-long one as extra latency. Same-device back-to-back reads reveal a wait applied where none is needed. The bench also holds a junk request during busy periods, and a controller that accepted it would corrupt the returned byte or the next latency.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ACCESS = 2'd2
    } rd_state_e;

    // Round a nanosecond delay up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_ce_decode.sv
module rom_ce_decode #(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_d,
    input  logic [SEL_W-1:0]   sel_d,
    output logic [NUM_DEV-1:0] ce_n
);

    logic [NUM_DEV-1:0] hit_d;
    logic [NUM_DEV-1:0] ce_n_d;
    logic [NUM_DEV-1:0] ce_n_q;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dec
        assign hit_d[i] = en_d && (sel_d == SEL_W'(i));
    end

    always_comb begin
        ce_n_d = ~hit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_n_q <= '1;
        else        ce_n_q <= ce_n_d;
    end

    assign ce_n = ce_n_q;

    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

endmodule

// File: rtl/rom_rel_timer.sv
module rom_rel_timer #(
    parameter int REL_CYC = 5,
    parameter int W       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clear
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = W'(REL_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Clear one edge early: the edge that consumes clear is the REL-th edge.
    assign clear = (cnt_q <= W'(1));

    // R6
    rel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear) |-> $past(start));

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int NUM_DEV       = 4,
    parameter int DEV_AW        = 18,
    parameter int DW            = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ADDR_NS     = 80,
    parameter int T_CE_NS       = 80,
    parameter int T_OE_NS       = 50,
    parameter int T_REL_NS      = 50,
    localparam int SEL_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int AW           = DEV_AW + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_addr,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_data,
    output logic [DEV_AW-1:0]  rom_addr,
    output logic [NUM_DEV-1:0] rom_ce_n,
    output logic               rom_oe_n,
    input  logic [DW-1:0]      rom_dq_in
);

    localparam int ACC_NS   = imax(T_ADDR_NS, T_CE_NS);
    localparam int ACC_CYC  = ns_to_cyc(ACC_NS, CLK_PERIOD_NS);
    localparam int LEAD_CYC = ns_to_cyc(imax(ACC_NS - T_OE_NS, 0), CLK_PERIOD_NS);
    localparam int OE_CYC   = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
    localparam int DONE_CYC = imax(ACC_CYC, LEAD_CYC + OE_CYC);
    localparam int REL_CYC  = ns_to_cyc(T_REL_NS, CLK_PERIOD_NS);
    localparam int CNT_W    = $clog2(DONE_CYC + 2);
    localparam int REL_W    = $clog2(REL_CYC + 2);
    localparam logic [CNT_W-1:0] DONE_T = CNT_W'(DONE_CYC);
    localparam logic [CNT_W-1:0] OE_AT  = CNT_W'((LEAD_CYC > 0) ? LEAD_CYC - 1 : 0);
    localparam logic             OE_NOW = (LEAD_CYC == 0);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   t;
        logic [SEL_W-1:0]   dev;
        logic [SEL_W-1:0]   last_dev;
        logic [DEV_AW-1:0]  addr;
        logic               ce_on;
        logic               oe_on;
        logic               rv;
        logic [DW-1:0]      rd;
    } ctl_s;

    ctl_s             d, q;
    logic             rel_start;
    logic             rel_clear;
    logic [SEL_W-1:0] req_dev;

    assign req_dev = req_addr[AW-1:DEV_AW];

    always_comb begin
        d         = q;
        d.rv      = 1'b0;
        rel_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr[DEV_AW-1:0];
                    d.dev  = req_dev;
                    if (req_dev == q.last_dev || rel_clear) begin
                        d.st       = ST_ACCESS;
                        d.ce_on    = 1'b1;
                        d.oe_on    = OE_NOW;
                        d.t        = '0;
                        d.last_dev = req_dev;
                    end else begin
                        d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (rel_clear) begin
                    d.st       = ST_ACCESS;
                    d.ce_on    = 1'b1;
                    d.oe_on    = OE_NOW;
                    d.t        = '0;
                    d.last_dev = q.dev;
                end
            end
            ST_ACCESS: begin
                if (q.t == DONE_T) begin
                    d.rd      = rom_dq_in;
                    d.rv      = 1'b1;
                    d.ce_on   = 1'b0;
                    d.oe_on   = 1'b0;
                    d.st      = ST_IDLE;
                    rel_start = 1'b1;
                end else begin
                    d.t = q.t + 1'b1;
                    if (!OE_NOW && q.t == OE_AT)
                        d.oe_on = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    rom_ce_decode #(
        .NUM_DEV (NUM_DEV),
        .SEL_W   (SEL_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en_d  (d.ce_on),
        .sel_d (d.dev),
        .ce_n  (rom_ce_n)
    );

    rom_rel_timer #(
        .REL_CYC (REL_CYC),
        .W       (REL_W)
    ) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rel_start),
        .clear (rel_clear)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rv;
    assign rsp_data  = q.rd;
    assign rom_addr  = q.addr;
    assign rom_oe_n  = ~q.oe_on;

    // Checker state: edges since the output enable last rose, and the last selected mask.
    localparam int GAP_W = $clog2(REL_CYC + 2);
    logic [GAP_W-1:0]   gap_q;
    logic [NUM_DEV-1:0] last_mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= GAP_W'(REL_CYC);
            last_mask_q <= '0;
        end else begin
            if (!rom_oe_n)                    gap_q <= '0;
            else if (gap_q < GAP_W'(REL_CYC)) gap_q <= gap_q + 1'b1;
            if (rom_ce_n != '1)               last_mask_q <= ~rom_ce_n;
        end
    end

    // R3
    oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> ($countones(~rom_ce_n) == 1));

    // R4
    cap_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!rom_oe_n));

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&rom_ce_n) && rom_oe_n));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_oe_n && $past(!rom_oe_n)) |-> ($stable(rom_addr) && $stable(rom_ce_n)));

    // R6
    rel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rom_ce_n != '1) && ($past(rom_ce_n) == '1) && ((~rom_ce_n) != last_mask_q))
        |-> (gap_q >= GAP_W'(REL_CYC)));

endmodule

// File: tb/rom_rd_ctrl_test.sv
module rom_rd_ctrl_test;

    localparam int P     = 10;
    localparam int NDEV  = 4;
    localparam int DAW   = 18;
    localparam int AWB   = 20;
    localparam int TA    = 80;
    localparam int TC    = 80;
    localparam int TO    = 50;
    localparam int TR    = 50;
    localparam int B_ACC  = (TA > TC) ? TA : TC;
    localparam int B_LEAD = (((B_ACC > TO) ? B_ACC - TO : 0) + P - 1) / P;
    localparam int B_A_C  = (B_ACC + P - 1) / P;
    localparam int B_O_C  = (TO + P - 1) / P;
    localparam int B_DONE = (B_A_C > B_LEAD + B_O_C) ? B_A_C : B_LEAD + B_O_C;
    localparam int B_REL  = (TR + P - 1) / P;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [AWB-1:0]   req_addr = '0;
    logic             rsp_valid;
    logic [7:0]       rsp_data;
    logic [DAW-1:0]   rom_addr;
    logic [NDEV-1:0]  rom_ce_n;
    logic             rom_oe_n;
    logic [7:0]       rom_dq_in = 8'h00;

    rom_rd_ctrl #(
        .NUM_DEV(NDEV), .DEV_AW(DAW), .DW(8), .CLK_PERIOD_NS(P),
        .T_ADDR_NS(TA), .T_CE_NS(TC), .T_OE_NS(TO), .T_REL_NS(TR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_dq_in(rom_dq_in)
    );

    always #(P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input int dv, input int a);
        int v;
        v = (a ^ (a >> 7) ^ (a >> 13)) & 255;
        v = (v * 29 + dv * 71 + 60) & 255;
        return v[7:0];
    endfunction

    // Device bank model
    int ce_cnt[NDEV];
    int rel_age[NDEV];
    bit rel_on[NDEV];
    int oe_cnt = 0;
    int addr_cnt = 0;
    logic [DAW-1:0] addr_prev = '0;
    int exp_dev = 0;
    bit f_cont, f_ce, f_oe, f_addr;

    always @(negedge clk) begin
        int drivers;
        int pick;
        if (!rst_n) begin
            for (int i = 0; i < NDEV; i++) begin
                ce_cnt[i] = 0; rel_age[i] = 0; rel_on[i] = 0;
            end
            oe_cnt = 0; addr_cnt = 0; rom_dq_in = 8'h00;
        end else begin
            for (int i = 0; i < NDEV; i++)
                ce_cnt[i] = rom_ce_n[i] ? 0 : ce_cnt[i] + 1;
            oe_cnt = rom_oe_n ? 0 : oe_cnt + 1;
            addr_cnt = (rom_addr != addr_prev) ? 1 : addr_cnt + 1;
            addr_prev = rom_addr;
            if (!rom_oe_n && oe_cnt > 1 && addr_cnt == 1) f_addr = 1;
            drivers = 0;
            pick = -1;
            for (int i = 0; i < NDEV; i++) begin
                if (!rom_ce_n[i] && !rom_oe_n) begin
                    rel_on[i] = 1; rel_age[i] = 0; pick = i;
                end else if (rel_on[i]) begin
                    rel_age[i]++;
                    if ((rel_age[i] - 1) * P + P/2 >= TR) rel_on[i] = 0;
                end
                if (rel_on[i]) drivers++;
            end
            if (drivers > 1) f_cont = 1;
            if (rom_ce_n != '1 && rom_ce_n != ~(NDEV'(1) << exp_dev)) f_ce = 1;
            if (oe_cnt == 1 && (pick < 0 || ce_cnt[(pick < 0) ? 0 : pick] != B_LEAD + 1)) f_oe = 1;
            if (drivers == 1 && pick >= 0 &&
                (ce_cnt[pick] - 1) * P + P/2 >= TC &&
                (oe_cnt - 1) * P + P/2 >= TO &&
                (addr_cnt - 1) * P + P/2 >= TA)
                rom_dq_in = rom_byte(pick, int'(rom_addr));
            else
                rom_dq_in = ~rom_byte((pick < 0) ? 0 : pick, int'(rom_addr));
        end
    end

    int last_r = -1000;
    int last_dev = 0;
    bit have_prev = 0;

    task automatic do_read(input int dv, input int a, input int gap, input bit junk);
        int acc_e, rsp_e, k, exp_lat;
        bit diff, rdy_bad;
        string tag;
        repeat (gap) @(negedge clk);
        exp_dev = dv;
        f_cont = 0; f_ce = 0; f_oe = 0; f_addr = 0;
        req_addr  = (AWB'(dv) << DAW) | AWB'(a & ((1 << DAW) - 1));
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc_e = cyc + 1;
        @(negedge clk);
        if (have_prev) check(!rsp_valid, "R5 pulse", rsp_valid, 0);
        req_valid = junk;
        if (junk) req_addr = AWB'($urandom);
        rdy_bad = 0;
        while (!rsp_valid) begin
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
        end
        rsp_e = cyc;
        req_valid = 1'b0;
        k = acc_e - last_r;
        diff = (dv != last_dev);
        exp_lat = B_DONE + 1 + ((diff && k < B_REL) ? B_REL - k : 0);
        tag = (diff && k < B_REL) ? "R6 latency" : (!diff ? "R7 latency" : "R4 latency");
        check(rsp_e - acc_e == exp_lat, tag, rsp_e - acc_e, exp_lat);
        check(rsp_data == rom_byte(dv, a & ((1 << DAW) - 1)), "R4 data", rsp_data,
              rom_byte(dv, a & ((1 << DAW) - 1)));
        check(!f_cont, "R6 contention", f_cont, 0);
        check(!f_ce, "R2 select", f_ce, 0);
        check(!f_oe, "R3 oe offset", f_oe, 0);
        check(!f_addr, "R10 addr hold", f_addr, 0);
        check(!rdy_bad, "R8 busy ready", rdy_bad, 0);
        check((&rom_ce_n) && rom_oe_n, "R9 standby", {rom_ce_n, rom_oe_n}, {NDEV+1{1'b1}});
        last_r = rsp_e; last_dev = dv; have_prev = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(rom_ce_n == '1, "R1 ce", rom_ce_n, 4'hF);
        check(rom_oe_n == 1'b1, "R1 oe", rom_oe_n, 1);
        // Directed corners
        do_read(0, 0, 0, 0);                 // lowest address
        do_read(3, (1 << DAW) - 1, 0, 0);    // R6: device change back to back
        do_read(3, 12345, 0, 0);             // R7: same device back to back
        do_read(1, 777, 2, 0);               // R6: partial gap
        do_read(2, 4242, B_REL, 0);          // gap equals release time
        do_read(2, 99, 0, 1);                // R8: junk request while busy
        do_read(0, 31337, 7, 1);
        for (int i = 0; i < 40; i++)
            do_read(int'($urandom % NDEV), int'($urandom), int'($urandom % 8), ($urandom % 4) == 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(P * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule